// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block is a purely combinational binary adder. It takes two unsigned operands and a carry input and returns the sum and the carry output in the same cycle. No register lies on any path. Every bit position first forms a generate term (both operand bits set) and a propagate term (either operand bit set). Small groups of bits then turn these terms into internal carries using flat sum-of-products equations. Each group also reports one generate and one propagate term for the group as a whole.

In the default arrangement, a second lookahead stage takes the group terms and the carry input and computes the carry into every group, with no ripple between groups. The final carry out is formed from the combined group terms in the same generate-or-propagate-and-carry form. A parameter selects a cheaper arrangement instead. In that arrangement wider lookahead blocks hand the carry from one block to the next in a ripple. Both arrangements must give the same results.

The block also exports a generate and a propagate term for the whole operand width, so a wider adder can place several of these blocks under an outer lookahead stage.

Top module: `lookahead_adder`

## Requirements
- R1: `sum_o` equals the low `WIDTH` bits of the arithmetic sum `a_i + b_i + c_in`.
- R2: `c_out` equals bit `WIDTH` of the arithmetic sum `a_i + b_i + c_in`.
- R3: `grp_p_o` is 1 exactly when every bit position has at least one operand bit set, that is when `a_i | b_i` is all ones.
- R4: `grp_g_o` is 1 exactly when `a_i + b_i` with no carry input exceeds `WIDTH` bits. The value of `c_in` does not affect it.
- R5: The outputs can be cascaded: `c_out` always equals `grp_g_o | (grp_p_o & c_in)`.
- R6: A carry input must propagate through every group. An all-ones operand plus an all-zeros operand with `c_in` = 1 gives a sum of zero and `c_out` = 1. An alternating pattern with its complement gives `grp_p_o` = 1 and `grp_g_o` = 0, and `c_out` follows `c_in`.
- R7: The block-ripple arrangement (`ARR` = `ARR_BLOCK_RIPPLE`) gives the same `sum_o`, `c_out`, `grp_p_o` and `grp_g_o` as the two-level arrangement for the same operands.
- R8: A 32-bit instance built as four 8-bit lookahead blocks with rippled block carries meets R1 to R4.
- R9: With both operands zero, `sum_o` equals `c_in`, and `c_out` and `grp_g_o` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| c_out | output | 1 | Carry out of the top bit |
| grp_p_o | output | 1 | Propagate term for the whole width |
| grp_g_o | output | 1 | Generate term for the whole width |

## Verification
The bench builds three instances that receive the same stimulus:
- a 16-bit two-level instance made of four 4-bit groups;
- a 16-bit block-ripple instance made of two 8-bit blocks;
- a 32-bit block-ripple instance made of four 8-bit blocks.

The two 16-bit instances let the second-level carries be compared directly against a rippled block carry. The 32-bit instance exercises a carry that must cross three block boundaries. Directed patterns push a carry through every group, set a full propagate chain with no generate, and drive zero operands. Random operands cover mixed generate and propagate positions.

// File: rtl/la_adder_pkg.sv
package la_adder_pkg;

    typedef enum logic {
        ARR_TWO_LEVEL    = 1'b0,
        ARR_BLOCK_RIPPLE = 1'b1
    } carry_arr_e;

endpackage

// File: rtl/la_carry_core.sv
// Flat sum-of-products carry network over N generate/propagate pairs.
// carry_o[j] is the carry into position j (carry_o[0] is c_in).
module la_carry_core #(
    parameter int N = 4
) (
    input  logic [N-1:0] g_i,
    input  logic [N-1:0] p_i,
    input  logic         c_in,
    output logic [N-1:0] carry_o,
    output logic         blk_g_o,
    output logic         blk_p_o
);

    always_comb begin
        logic acc;
        logic term;
        for (int j = 0; j < N; j++) begin
            term = c_in;
            for (int m = 0; m < j; m++) begin
                term = term & p_i[m];
            end
            acc = term;
            for (int k = 0; k < j; k++) begin
                term = g_i[k];
                for (int m = k + 1; m < j; m++) begin
                    term = term & p_i[m];
                end
                acc = acc | term;
            end
            carry_o[j] = acc;
        end
    end

    always_comb begin
        logic acc;
        logic term;
        acc = 1'b0;
        for (int k = 0; k < N; k++) begin
            term = g_i[k];
            for (int m = k + 1; m < N; m++) begin
                term = term & p_i[m];
            end
            acc = acc | term;
        end
        blk_g_o = acc;
        blk_p_o = &p_i;
    end

endmodule

// File: rtl/la_group.sv
// One lookahead group: bit terms, internal carries, sum and group terms.
module la_group #(
    parameter int GW = 4
) (
    input  logic [GW-1:0] a_i,
    input  logic [GW-1:0] b_i,
    input  logic          c_in,
    output logic [GW-1:0] sum_o,
    output logic          gg_o,
    output logic          gp_o
);

    logic [GW-1:0] bit_g;
    logic [GW-1:0] bit_p;
    logic [GW-1:0] bit_c;

    assign bit_g = a_i & b_i;
    assign bit_p = a_i | b_i;

    la_carry_core #(.N(GW)) core_i (
        .g_i     (bit_g),
        .p_i     (bit_p),
        .c_in    (c_in),
        .carry_o (bit_c),
        .blk_g_o (gg_o),
        .blk_p_o (gp_o)
    );

    // OR-formed propagate cannot build the sum; XOR is needed here.
    assign sum_o = a_i ^ b_i ^ bit_c;

endmodule

// File: rtl/lookahead_adder.sv
module lookahead_adder
    import la_adder_pkg::*;
#(
    parameter int         WIDTH = 16,
    parameter int         GRP_W = 4,
    parameter int         BLK_W = 8,
    parameter carry_arr_e ARR   = ARR_TWO_LEVEL
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum_o,
    output logic             c_out,
    output logic             grp_p_o,
    output logic             grp_g_o
);

    localparam int UNIT_W = (ARR == ARR_TWO_LEVEL) ? GRP_W : BLK_W;
    localparam int NUNIT  = WIDTH / UNIT_W;

    logic [NUNIT-1:0] unit_g;
    logic [NUNIT-1:0] unit_p;
    logic [NUNIT-1:0] unit_c;

    for (genvar k = 0; k < NUNIT; k++) begin : g_unit
        la_group #(.GW(UNIT_W)) grp_i (
            .a_i   (a_i[k*UNIT_W +: UNIT_W]),
            .b_i   (b_i[k*UNIT_W +: UNIT_W]),
            .c_in  (unit_c[k]),
            .sum_o (sum_o[k*UNIT_W +: UNIT_W]),
            .gg_o  (unit_g[k]),
            .gp_o  (unit_p[k])
        );
    end

    if (ARR == ARR_TWO_LEVEL) begin : g_two_level
        logic top_g;
        logic top_p;

        la_carry_core #(.N(NUNIT)) lookahead_i (
            .g_i     (unit_g),
            .p_i     (unit_p),
            .c_in    (c_in),
            .carry_o (unit_c),
            .blk_g_o (top_g),
            .blk_p_o (top_p)
        );

        assign c_out   = top_g | (top_p & c_in);
        assign grp_g_o = top_g;
        assign grp_p_o = top_p;
    end else begin : g_block_ripple
        logic [NUNIT:0] chain;

        assign chain[0] = c_in;
        for (genvar k = 0; k < NUNIT; k++) begin : g_link
            assign chain[k+1] = unit_g[k] | (unit_p[k] & chain[k]);
        end
        assign unit_c = chain[NUNIT-1:0];
        assign c_out  = chain[NUNIT];

        always_comb begin
            logic acc_g;
            logic acc_p;
            acc_g = 1'b0;
            acc_p = 1'b1;
            for (int k = 0; k < NUNIT; k++) begin
                acc_g = unit_g[k] | (unit_p[k] & acc_g);
                acc_p = acc_p & unit_p[k];
            end
            grp_g_o = acc_g;
            grp_p_o = acc_p;
        end
    end

endmodule

// File: rtl/lookahead_adder_chk.sv
module lookahead_adder_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             c_in,
    input logic [WIDTH-1:0] sum_o,
    input logic             c_out,
    input logic             grp_p_o,
    input logic             grp_g_o
);

    logic [WIDTH:0] total;
    logic [WIDTH:0] no_cin;

    assign total  = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, c_in};
    assign no_cin = {1'b0, a_i} + {1'b0, b_i};

    always_comb begin
        if (!$isunknown({a_i, b_i, c_in})) begin
            AST_SUM_LOW: assert (sum_o == total[WIDTH-1:0])
                else $error("sum mismatch"); // R1
            AST_CARRY_OUT: assert (c_out == total[WIDTH])
                else $error("carry out mismatch"); // R2
            AST_GRP_PROP: assert (grp_p_o == (&(a_i | b_i)))
                else $error("group propagate mismatch"); // R3
            AST_GRP_GEN: assert (grp_g_o == no_cin[WIDTH])
                else $error("group generate mismatch"); // R4
            AST_CASCADE: assert (c_out == (grp_g_o | (grp_p_o & c_in)))
                else $error("cascade relation broken"); // R5
            AST_ZERO_IN: assert (!((a_i == '0) && (b_i == '0)) ||
                                 ((sum_o == {{(WIDTH-1){1'b0}}, c_in}) && !c_out && !grp_g_o))
                else $error("zero operand result wrong"); // R9
        end
    end

endmodule

bind lookahead_adder lookahead_adder_chk #(.WIDTH(WIDTH)) chk_i (
    .a_i     (a_i),
    .b_i     (b_i),
    .c_in    (c_in),
    .sum_o   (sum_o),
    .c_out   (c_out),
    .grp_p_o (grp_p_o),
    .grp_g_o (grp_g_o)
);

// File: tb/lookahead_adder_tb_top.sv
module lookahead_adder_tb_top;
    import la_adder_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [31:0] a32 = '0;
    logic [31:0] b32 = '0;
    logic        ci  = 1'b0;

    logic [15:0] s_two, s_rip;
    logic [31:0] s_wide;
    logic co_two, co_rip, co_wide;
    logic p_two, p_rip, p_wide;
    logic g_two, g_rip, g_wide;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    lookahead_adder #(.WIDTH(16), .GRP_W(4), .BLK_W(8), .ARR(ARR_TWO_LEVEL)) dut_i (
        .a_i(a32[15:0]), .b_i(b32[15:0]), .c_in(ci),
        .sum_o(s_two), .c_out(co_two), .grp_p_o(p_two), .grp_g_o(g_two));

    lookahead_adder #(.WIDTH(16), .GRP_W(4), .BLK_W(8), .ARR(ARR_BLOCK_RIPPLE)) dut_rip_i (
        .a_i(a32[15:0]), .b_i(b32[15:0]), .c_in(ci),
        .sum_o(s_rip), .c_out(co_rip), .grp_p_o(p_rip), .grp_g_o(g_rip));

    lookahead_adder #(.WIDTH(32), .GRP_W(4), .BLK_W(8), .ARR(ARR_BLOCK_RIPPLE)) dut_wide_i (
        .a_i(a32), .b_i(b32), .c_in(ci),
        .sum_o(s_wide), .c_out(co_wide), .grp_p_o(p_wide), .grp_g_o(g_wide));

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h (a=%h b=%h cin=%0b)", tag, act, exp, a32, b32, ci);
        end
    endtask

    // Behavioural reference: plain integer addition, compared each vector.
    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic c);
        logic [16:0] t16, n16;
        logic [32:0] t32, n32;
        @(posedge clk);
        a32 = a;
        b32 = b;
        ci  = c;
        @(negedge clk);
        t16 = {1'b0, a[15:0]} + {1'b0, b[15:0]} + {16'd0, c};
        n16 = {1'b0, a[15:0]} + {1'b0, b[15:0]};
        t32 = {1'b0, a} + {1'b0, b} + {32'd0, c};
        n32 = {1'b0, a} + {1'b0, b};
        check("R1 two-level sum", 64'(s_two), 64'(t16[15:0]));
        check("R2 two-level carry out", 64'(co_two), 64'(t16[16]));
        check("R3 two-level group P", 64'(p_two), 64'(&(a[15:0] | b[15:0])));
        check("R4 two-level group G", 64'(g_two), 64'(n16[16]));
        check("R5 cascade relation", 64'(co_two), 64'(g_two | (p_two & c)));
        check("R7 ripple sum vs two-level", 64'(s_rip), 64'(s_two));
        check("R7 ripple carry vs reference", 64'(co_rip), 64'(t16[16]));
        check("R7 ripple P/G vs two-level", 64'({p_rip, g_rip}), 64'({p_two, g_two}));
        check("R8 32-bit sum", 64'(s_wide), 64'(t32[31:0]));
        check("R8 32-bit carry out", 64'(co_wide), 64'(t32[32]));
        check("R8 32-bit group P/G", 64'({p_wide, g_wide}),
              64'({&(a | b), n32[32]}));
    endtask

    initial begin
        // reset-like idle state: zero operands
        apply(32'd0, 32'd0, 1'b0);
        check("R9 zero sum cin=0", 64'(s_two), 64'd0);
        check("R9 zero carry/G cin=0", 64'({co_two, g_two}), 64'd0);
        apply(32'd0, 32'd0, 1'b1);
        check("R9 zero sum cin=1", 64'(s_two), 64'd1);
        check("R9 zero wide sum cin=1", 64'(s_wide), 64'd1);
        // all ones plus carry in: carry crosses every group
        apply(32'hFFFF_FFFF, 32'd0, 1'b1);
        check("R6 all-ones+1 sum", 64'({s_two, s_rip}), 64'd0);
        check("R6 all-ones+1 carry", 64'({co_two, co_rip, co_wide}), 64'h7);
        apply(32'hFFFF_FFFF, 32'd1, 1'b0);
        check("R6 all-ones plus one operand", 64'({co_two, s_two}), 64'h1_0000);
        // full propagate chain, no generate
        apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
        check("R6 chain P/G", 64'({p_two, g_two}), 64'h2);
        check("R6 chain carry off", 64'(co_two), 64'd0);
        apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
        check("R6 chain carry follows cin", 64'({co_two, co_wide}), 64'h3);
        // generate only in top bit
        apply(32'h8000_8000, 32'h8000_8000, 1'b0);
        check("R4 top generate", 64'({g_two, g_wide}), 64'h3);
        apply(32'h7FFF_7FFF, 32'h0000_0000, 1'b1);
        apply(32'h0000_0FFF, 32'h0000_F001, 1'b0);
        for (int i = 0; i < 400; i++) begin
            apply($urandom, $urandom, 1'($urandom));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule